// File: doc/BRIEF.md
# Source-Side Per-Port Transfer Credit Tracker

This block sits beside the data scheduler of a multi-port sender. It keeps one transfer-credit counter for each port of the interface. A status channel delivers one status bit per port. A zero bit means the far end can take a fresh batch of transfers, so the port's counter is loaded with that port's programmed batch size. A one bit gives no new credit, but the port may still use whatever balance it holds. Each time the scheduler picks a port for a transfer, that port's counter drops by one.

A grant overwrites the balance and never adds to it. The credit in force for a port therefore always comes from the latest status seen for that port. For every port the block presents one ready bit, which is high while at least one credit remains, so the scheduler can skip ports that have nothing to spend. If a selection arrives for a port that has no credit, the block raises a one-cycle error flag and the counter stays at zero. The batch size of each port can be rewritten at run time.

Top module: `credit_tracker`

## Requirements
- R1: While reset (`rst_n` low) is applied, and on the first edge after it, every `port_ready` bit is 0 and `sel_err` is 0. Reset also sets every port's programmed batch size back to `DEF_CREDIT`.
- R2: A status update with `st_bit` = 0 for port p loads p's counter with p's programmed batch size. The bit `port_ready[p]` reflects the new count after the next clock edge, and exactly that many selections of p are then possible before `port_ready[p]` falls.
- R3: A zero-status grant replaces any balance still left on the port. It is not added to that balance.
- R4: A status update with `st_bit` = 1 leaves the port's counter unchanged.
- R5: Each selection of port p (`sel_valid` high, `sel_port` = p) lowers p's counter by one. `port_ready[p]` goes low on the edge that takes the last credit.
- R6: When a status update and a selection hit the same port in one cycle, the result depends on the status bit. With a 0 status the counter becomes the batch size minus one. With a 1 status it becomes the old balance minus one.
- R7: A selection of a port whose balance is zero raises `sel_err` for exactly the one cycle after that edge, and the counter stays at zero. The balance is taken after any same-cycle zero-status grant is applied.
- R8: A write (`cfg_we` high) sets port `cfg_port`'s batch size to `cfg_val` for grants in later cycles. It does not change the current balance. A grant in the same cycle as the write uses the previous batch size. A batch size of 0 makes a grant leave the port not ready.
- R9: Status and selection events act only on the port they name. A status update on one port and a selection on another port in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Status update present this cycle |
| st_port | input | PORT_W | Port named by the status update |
| st_bit | input | 1 | Status value: 0 grants a fresh batch, 1 grants nothing |
| sel_valid | input | 1 | Scheduler selected a port this cycle |
| sel_port | input | PORT_W | Port selected for a transfer |
| cfg_we | input | 1 | Write a port's batch size |
| cfg_port | input | PORT_W | Port whose batch size is written |
| cfg_val | input | CREDIT_W | New batch size |
| port_ready | output | NUM_PORTS | Bit p high while port p holds at least one credit |
| sel_err | output | 1 | A selection hit a port with no credit on the previous edge |

## Verification
The bench aims at the cases where the ordering of events in one cycle matters.

- **Status and selection on the same port.** A design that let the selection use the stale balance would leave the wrong count after the grant.
- **Grant while credit remains.** A design that added credit instead of replacing it would allow more selections before `port_ready` drops.
- **Batch-size write in the same cycle as a grant.** A design that forwarded the new value would load the wrong count.

Credit counts are measured only at the ports, by selecting a port until its ready bit falls. This also exposes off-by-one faults in how `port_ready` clears. Selections of empty ports, including one right after a zero-size grant, check that the error flag fires and that the counter does not wrap to its maximum.

// File: rtl/credit_pkg.sv
package credit_pkg;

  // Meaning of the status bit carried by the status channel.
  typedef enum logic {
    ST_GRANT = 1'b0,
    ST_HOLD  = 1'b1
  } status_e;

endpackage

// File: rtl/credit_cfg_bank.sv
module credit_cfg_bank #(
  parameter int NUM_PORTS  = 64,
  parameter int CREDIT_W   = 8,
  parameter int DEF_CREDIT = 6,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [PORT_W-1:0]   wr_port,
  input  logic [CREDIT_W-1:0] wr_val,
  output logic [CREDIT_W-1:0] size_q [NUM_PORTS]
);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_lane
    logic wr_hit;
    assign wr_hit = wr_en && (wr_port == PORT_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)      size_q[i] <= CREDIT_W'(DEF_CREDIT);
      else if (wr_hit) size_q[i] <= wr_val;
    end

    // R8: a write lands in the addressed lane on the next edge
    a_r8_cfg_store: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> size_q[i] == $past(wr_val));
  end

endmodule

// File: rtl/credit_counter.sv
module credit_counter #(
  parameter int CREDIT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                grant,
  input  logic                take,
  input  logic [CREDIT_W-1:0] batch,
  output logic                has_credit,
  output logic                uflow
);

  logic [CREDIT_W-1:0] cnt_q;
  logic [CREDIT_W-1:0] base;
  logic [CREDIT_W-1:0] cnt_d;

  // Balance the selection spends from: a fresh grant replaces the old one.
  function automatic logic [CREDIT_W-1:0] base_of(
    input logic [CREDIT_W-1:0] cur,
    input logic [CREDIT_W-1:0] sz,
    input logic                g);
    return g ? sz : cur;
  endfunction

  // Spend one credit if one is there; an empty port stays at zero.
  function automatic logic [CREDIT_W-1:0] spend(
    input logic [CREDIT_W-1:0] b,
    input logic                t);
    return (t && (b != '0)) ? b - 1'b1 : b;
  endfunction

  assign base       = base_of(cnt_q, batch, grant);
  assign cnt_d      = spend(base, take);
  assign uflow      = take && (base == '0);
  assign has_credit = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2 and R3: a lone grant loads the batch size, whatever the old balance
  a_r3_grant_replaces: assert property (@(posedge clk) disable iff (!rst_n)
    grant && !take |=> cnt_q == $past(batch));

  // R4: no grant and no selection leaves the balance alone
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !grant && !take |=> $stable(cnt_q));

  // R5: a selection on a non-empty port without a grant spends one
  a_r5_spend: assert property (@(posedge clk) disable iff (!rst_n)
    take && !grant && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R6: a grant and a selection in one cycle leave batch minus one
  a_r6_both: assert property (@(posedge clk) disable iff (!rst_n)
    take && grant && (batch != '0) |=> cnt_q == $past(batch) - 1'b1);

  // R7: selecting an empty port does not wrap the counter
  a_r7_floor: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |=> cnt_q == '0);

endmodule

// File: rtl/credit_tracker.sv
module credit_tracker #(
  parameter int NUM_PORTS  = 64,
  parameter int CREDIT_W   = 8,
  parameter int DEF_CREDIT = 6,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 st_valid,
  input  logic [PORT_W-1:0]    st_port,
  input  logic                 st_bit,
  input  logic                 sel_valid,
  input  logic [PORT_W-1:0]    sel_port,
  input  logic                 cfg_we,
  input  logic [PORT_W-1:0]    cfg_port,
  input  logic [CREDIT_W-1:0]  cfg_val,
  output logic [NUM_PORTS-1:0] port_ready,
  output logic                 sel_err
);
  import credit_pkg::*;

  logic [CREDIT_W-1:0]  size_q [NUM_PORTS];
  logic [NUM_PORTS-1:0] grant_vec;
  logic [NUM_PORTS-1:0] take_vec;
  logic [NUM_PORTS-1:0] uflow_vec;
  logic                 sel_err_q;

  credit_cfg_bank #(
    .NUM_PORTS (NUM_PORTS),
    .CREDIT_W  (CREDIT_W),
    .DEF_CREDIT(DEF_CREDIT)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_port(cfg_port),
    .wr_val (cfg_val),
    .size_q (size_q)
  );

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    assign grant_vec[i] = st_valid && (status_e'(st_bit) == ST_GRANT)
                          && (st_port == PORT_W'(i));
    assign take_vec[i]  = sel_valid && (sel_port == PORT_W'(i));

    credit_counter #(.CREDIT_W(CREDIT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .grant     (grant_vec[i]),
      .take      (take_vec[i]),
      .batch     (size_q[i]),
      .has_credit(port_ready[i]),
      .uflow     (uflow_vec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel_err_q <= 1'b0;
    else        sel_err_q <= |uflow_vec;
  end
  assign sel_err = sel_err_q;

  // R7: the error flag follows a selection on the previous edge
  a_r7_err_after_sel: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> $past(sel_valid));

  // R9: at most one port is touched by a selection
  a_r9_single_take: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(uflow_vec));

endmodule

// File: tb/credit_tracker_tb.sv
module credit_tracker_tb;

  localparam int NP = 64;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_valid = 1'b0;
  logic [5:0]    st_port = '0;
  logic          st_bit = 1'b0;
  logic          sel_valid = 1'b0;
  logic [5:0]    sel_port = '0;
  logic          cfg_we = 1'b0;
  logic [5:0]    cfg_port = '0;
  logic [CW-1:0] cfg_val = '0;
  logic [NP-1:0] port_ready;
  logic          sel_err;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  credit_tracker #(.NUM_PORTS(NP), .CREDIT_W(CW), .DEF_CREDIT(6)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_port(st_port), .st_bit(st_bit),
    .sel_valid(sel_valid), .sel_port(sel_port),
    .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_val(cfg_val),
    .port_ready(port_ready), .sel_err(sel_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<=100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs starting just after a falling edge; return
  // after the next falling edge with all strobes cleared.
  task automatic step(input bit sv, input int sp, input bit sb,
                      input bit lv, input int lp);
    st_valid  = sv; st_port  = 6'(sp); st_bit = sb;
    sel_valid = lv; sel_port = 6'(lp);
    @(negedge clk);
    st_valid = 1'b0; sel_valid = 1'b0; cfg_we = 1'b0;
  endtask

  // Count selections of port p until its ready bit falls.
  task automatic drain(input int p, input int exp, input string req);
    int n = 0;
    while (port_ready[p] && n < 400) begin
      step(1'b0, 0, 1'b0, 1'b1, p);
      n++;
    end
    check(n == exp, req, n, exp);
  endtask

  typedef struct packed {
    logic       sv;
    logic [5:0] sp;
    logic       sb;
    logic       lv;
    logic [5:0] lp;
    logic [5:0] cp;
    logic       ea;
    logic       ee;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 6'd0, 1'b0, 1'b1, 6'd3, 6'd3, 1'b0, 1'b1, 4'd7}, // R7 empty select
    '{1'b1, 6'd3, 1'b0, 1'b0, 6'd0, 6'd3, 1'b1, 1'b0, 4'd2}, // R2 grant p3=6
    '{1'b0, 6'd0, 1'b0, 1'b1, 6'd3, 6'd3, 1'b1, 1'b0, 4'd5}, // R5 p3=5
    '{1'b1, 6'd3, 1'b1, 1'b1, 6'd5, 6'd3, 1'b1, 1'b1, 4'd4}, // R4 hold, p5 empty
    '{1'b1, 6'd5, 1'b0, 1'b1, 6'd3, 6'd5, 1'b1, 1'b0, 4'd9}, // R9 p5=6, p3=4
    '{1'b0, 6'd0, 1'b0, 1'b1, 6'd3, 6'd3, 1'b1, 1'b0, 4'd5}, // p3=3
    '{1'b0, 6'd0, 1'b0, 1'b1, 6'd3, 6'd3, 1'b1, 1'b0, 4'd5}, // p3=2
    '{1'b0, 6'd0, 1'b0, 1'b1, 6'd3, 6'd3, 1'b1, 1'b0, 4'd5}, // p3=1
    '{1'b0, 6'd0, 1'b0, 1'b1, 6'd3, 6'd3, 1'b0, 1'b0, 4'd5}, // R5 p3=0
    '{1'b1, 6'd3, 1'b1, 1'b0, 6'd0, 6'd3, 1'b0, 1'b0, 4'd4}, // R4 no grant
    '{1'b1, 6'd3, 1'b0, 1'b1, 6'd3, 6'd3, 1'b1, 1'b0, 4'd6}, // R6 p3=5
    '{1'b1, 6'd3, 1'b1, 1'b1, 6'd3, 6'd3, 1'b1, 1'b0, 4'd6}  // R6 p3=4
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check(port_ready == '0, "R1 ready in reset", int'(port_ready != '0), 0);
    check(sel_err == 1'b0, "R1 err in reset", int'(sel_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(port_ready == '0, "R1 ready after reset", int'(port_ready != '0), 0);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k].sv, int'(VEC[k].sp), VEC[k].sb, VEC[k].lv, int'(VEC[k].lp));
      check(port_ready[VEC[k].cp] == VEC[k].ea, $sformatf("R%0d ready vec%0d", VEC[k].req, k),
            int'(port_ready[VEC[k].cp]), int'(VEC[k].ea));
      check(sel_err == VEC[k].ee, $sformatf("R%0d err vec%0d", VEC[k].req, k),
            int'(sel_err), int'(VEC[k].ee));
    end

    // R6: balance left after the mixed cycles
    drain(3, 4, "R6 drain p3");
    // R9: draining p3 left p5 untouched
    check(port_ready[5] == 1'b1, "R9 p5 kept", int'(port_ready[5]), 1);

    // R3: grant over a remaining balance replaces it
    step(1'b0, 0, 1'b0, 1'b1, 5);
    step(1'b0, 0, 1'b0, 1'b1, 5);
    step(1'b1, 5, 1'b0, 1'b0, 0);
    drain(5, 6, "R3 replace p5");

    // R8: same-cycle write and grant uses the old size
    cfg_we = 1'b1; cfg_port = 6'd7; cfg_val = 8'd3;
    step(1'b1, 7, 1'b0, 1'b0, 0);
    drain(7, 6, "R8 old size p7");
    step(1'b1, 7, 1'b0, 1'b0, 0);
    drain(7, 3, "R8 new size p7");

    // R8: a write does not touch the live balance
    step(1'b1, 9, 1'b0, 1'b0, 0);
    cfg_we = 1'b1; cfg_port = 6'd9; cfg_val = 8'd2;
    step(1'b0, 0, 1'b0, 1'b0, 0);
    drain(9, 6, "R8 balance kept p9");

    // R8 and R7: zero size grant, then select the empty port
    cfg_we = 1'b1; cfg_port = 6'd10; cfg_val = 8'd0;
    step(1'b0, 0, 1'b0, 1'b0, 0);
    step(1'b1, 10, 1'b0, 1'b0, 0);
    check(port_ready[10] == 1'b0, "R8 zero size", int'(port_ready[10]), 0);
    step(1'b0, 0, 1'b0, 1'b1, 10);
    check(sel_err == 1'b1, "R7 err zero size", int'(sel_err), 1);
    step(1'b0, 0, 1'b0, 1'b0, 0);
    check(sel_err == 1'b0, "R7 err one cycle", int'(sel_err), 0);

    // R2: largest batch size
    cfg_we = 1'b1; cfg_port = 6'd11; cfg_val = 8'd255;
    step(1'b0, 0, 1'b0, 1'b0, 0);
    step(1'b1, 11, 1'b0, 1'b0, 0);
    drain(11, 255, "R2 max p11");

    // R1: reset mid-run restores the default batch size
    cfg_we = 1'b1; cfg_port = 6'd12; cfg_val = 8'd3;
    step(1'b1, 13, 1'b0, 1'b0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    check(port_ready == '0, "R1 mid reset", int'(port_ready != '0), 0);
    rst_n = 1'b1;
    step(1'b1, 12, 1'b0, 1'b0, 0);
    drain(12, 6, "R1 default size p12");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule